// File: doc/BRIEF.md
# Wall-Following Steering Controller

This block steers a small maze-walking robot that keeps a wall on its right-hand side. Two touch feelers, one on each side of the robot's front, report whether they are in contact with a wall. From these two bits the controller picks one of four behaviours: searching for a wall, turning away from a wall ahead, running along a wall it is touching, or curving back toward a wall it has lost. It then drives three actuator commands: step forward, veer left and veer right.

The controller is a Moore machine. The commands depend only on the stored behaviour, so they change only on a rising clock edge and never follow the feelers within a cycle. Both feeler inputs must already be synchronous to the clock. A synchronous, active-high reset puts the robot into the wall-search behaviour. The behaviour is held in a two-bit register with the codes search = 00, blocked = 01, hugging = 10, gap = 11.

Top module: `wallfollow_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is search. In search, `cmd_fwd`=1, `cmd_veer_left`=0 and `cmd_veer_right`=0.
- R2: In search, if either feeler is 1 the next state is blocked, and if both are 0 the state stays search. Blocked drives only `cmd_veer_left`=1.
- R3: In blocked, the state stays blocked while either feeler is 1, and it moves to gap when both are 0. Gap drives `cmd_fwd`=1 and `cmd_veer_right`=1.
- R4: In hugging, `touch_left`=1 moves to blocked whatever `touch_right` is. `touch_left`=0 with `touch_right`=1 stays in hugging, and both 0 moves to gap. Hugging drives `cmd_fwd`=1 and `cmd_veer_left`=1.
- R5: In gap, `touch_right`=1 moves to hugging, and `touch_right`=0 stays in gap. `touch_left` has no effect in gap.
- R6: The outputs change only at rising clock edges. A change on the feelers between edges leaves them unchanged, `cmd_veer_left` and `cmd_veer_right` are never both 1, and at least one output is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| touch_left | input | 1 | Left feeler touches a wall |
| touch_right | input | 1 | Right feeler touches a wall |
| cmd_fwd | output | 1 | Step forward |
| cmd_veer_left | output | 1 | Turn slightly left |
| cmd_veer_right | output | 1 | Turn slightly right |

## Verification
The hugging state is the hardest to reach. It is entered only from gap, and gap is entered only once the robot has been blocked and then lost contact. So the stimulus has to walk search → blocked → gap → hugging before it can test hugging's three exits, and it must repeat that walk for each exit. Gap's indifference to the left feeler also needs the left feeler held high while the right one stays clear, which is a pattern a random run seldom keeps. The directed sequences build these paths on purpose, and a long pseudo-random sweep follows them, with the reference model checked on every clock.

// File: rtl/wf_pkg.sv
package wf_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_SEARCH  = 2'b00,
        ST_BLOCKED = 2'b01,
        ST_HUGGING = 2'b10,
        ST_GAP     = 2'b11
    } wf_state_t;

    typedef struct packed {
        logic left;
        logic right;
    } feelers_t;

    typedef struct packed {
        logic fwd;
        logic veer_left;
        logic veer_right;
    } drive_t;

    function automatic wf_state_t wf_next(input wf_state_t cur, input feelers_t f);
        wf_state_t nxt;
        nxt = cur;
        unique case (cur)
            ST_SEARCH:  nxt = (f.left || f.right) ? ST_BLOCKED : ST_SEARCH;
            ST_BLOCKED: nxt = (f.left || f.right) ? ST_BLOCKED : ST_GAP;
            ST_HUGGING: begin
                if (f.left)       nxt = ST_BLOCKED;
                else if (f.right) nxt = ST_HUGGING;
                else              nxt = ST_GAP;
            end
            ST_GAP:     nxt = f.right ? ST_HUGGING : ST_GAP;
            default:    nxt = ST_SEARCH;
        endcase
        return nxt;
    endfunction

    function automatic drive_t wf_decode(input wf_state_t cur);
        drive_t d;
        d = '0;
        unique case (cur)
            ST_SEARCH:  d = '{fwd: 1'b1, veer_left: 1'b0, veer_right: 1'b0};
            ST_BLOCKED: d = '{fwd: 1'b0, veer_left: 1'b1, veer_right: 1'b0};
            ST_HUGGING: d = '{fwd: 1'b1, veer_left: 1'b1, veer_right: 1'b0};
            ST_GAP:     d = '{fwd: 1'b1, veer_left: 1'b0, veer_right: 1'b1};
            default:    d = '{fwd: 1'b1, veer_left: 1'b0, veer_right: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wf_next_logic.sv
module wf_next_logic
    import wf_pkg::*;
(
    input  wf_state_t cur_state,
    input  feelers_t  feel,
    output wf_state_t nxt_state
);
    always_comb begin
        nxt_state = wf_next(cur_state, feel);
    end
endmodule

// File: rtl/wf_state_reg.sv
module wf_state_reg
    import wf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wf_state_t d_state,
    output wf_state_t q_state
);
    always_ff @(posedge clk) begin
        if (rst) q_state <= ST_SEARCH;
        else     q_state <= d_state;
    end
endmodule

// File: rtl/wf_cmd_decode.sv
module wf_cmd_decode
    import wf_pkg::*;
(
    input  wf_state_t cur_state,
    output drive_t    drive
);
    always_comb begin
        drive = wf_decode(cur_state);
    end
endmodule

// File: rtl/wallfollow_ctrl.sv
module wallfollow_ctrl
    import wf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic touch_left,
    input  logic touch_right,
    output logic cmd_fwd,
    output logic cmd_veer_left,
    output logic cmd_veer_right
);
    feelers_t  feel;
    wf_state_t cur_state;
    wf_state_t nxt_state;
    drive_t    drive;

    assign feel = '{left: touch_left, right: touch_right};

    wf_next_logic u_next (
        .cur_state (cur_state),
        .feel      (feel),
        .nxt_state (nxt_state)
    );

    wf_state_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .d_state (nxt_state),
        .q_state (cur_state)
    );

    wf_cmd_decode u_dec (
        .cur_state (cur_state),
        .drive     (drive)
    );

    assign cmd_fwd        = drive.fwd;
    assign cmd_veer_left  = drive.veer_left;
    assign cmd_veer_right = drive.veer_right;
endmodule

// File: rtl/wallfollow_ctrl_chk.sv
module wallfollow_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic touch_left,
    input logic touch_right,
    input logic cmd_fwd,
    input logic cmd_veer_left,
    input logic cmd_veer_right
);
    logic in_search, in_blocked, in_hugging, in_gap;
    assign in_search  =  cmd_fwd && !cmd_veer_left && !cmd_veer_right;
    assign in_blocked = !cmd_fwd &&  cmd_veer_left && !cmd_veer_right;
    assign in_hugging =  cmd_fwd &&  cmd_veer_left && !cmd_veer_right;
    assign in_gap     =  cmd_fwd && !cmd_veer_left &&  cmd_veer_right;

    // R1
    reset_search_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> in_search);

    // R2
    search_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_search && (touch_left || touch_right)) |=> in_blocked);

    // R3
    blocked_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_blocked && !touch_left && !touch_right) |=> in_gap);

    // R4
    hug_left_chk: assert property (@(posedge clk) disable iff (rst)
        (in_hugging && touch_left) |=> in_blocked);

    // R5
    gap_right_chk: assert property (@(posedge clk) disable iff (rst)
        (in_gap && touch_right) |=> in_hugging);

    // R5
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_gap && !touch_right) |=> in_gap);

    // R6
    veer_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_veer_left && cmd_veer_right));

    // R6
    some_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({cmd_fwd, cmd_veer_left, cmd_veer_right}) != 0);
endmodule

bind wallfollow_ctrl wallfollow_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .touch_left     (touch_left),
    .touch_right    (touch_right),
    .cmd_fwd        (cmd_fwd),
    .cmd_veer_left  (cmd_veer_left),
    .cmd_veer_right (cmd_veer_right)
);

// File: tb/wallfollow_ctrl_tb_top.sv
`timescale 1ns/1ps
module wallfollow_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tl = 1'b0;
    logic tr = 1'b0;
    logic o_fwd, o_vl, o_vr;

    int checks = 0;
    int errors = 0;
    int mstate = 0;   // 0 search, 1 blocked, 2 hugging, 3 gap
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wallfollow_ctrl dut_i (
        .clk            (clk),
        .rst            (rst),
        .touch_left     (tl),
        .touch_right    (tr),
        .cmd_fwd        (o_fwd),
        .cmd_veer_left  (o_vl),
        .cmd_veer_right (o_vr)
    );

    function automatic logic [2:0] exp_out(input int s);
        case (s)
            0: return 3'b100;
            1: return 3'b010;
            2: return 3'b110;
            default: return 3'b101;
        endcase
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag);
        logic [2:0] act, exp;
        act = {o_fwd, o_vl, o_vr};
        exp = exp_out(mstate);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b (model state %0d)", tag, act, exp, mstate);
        end
    endtask

    // one clock: drive inputs at the falling edge, check mid-cycle stability,
    // update the model at the rising edge, check just after it
    task automatic step(input logic l, input logic r, input logic do_rst);
        string tg;
        @(negedge clk);
        tl = l; tr = r; rst = do_rst;
        #1;
        check("R6");
        tg = do_rst ? "R1" : tag_of(mstate);
        @(posedge clk);
        if (do_rst) mstate = 0;
        else begin
            case (mstate)
                0: mstate = (l || r) ? 1 : 0;
                1: mstate = (l || r) ? 1 : 3;
                2: mstate = l ? 1 : (r ? 2 : 3);
                default: mstate = r ? 2 : 3;
            endcase
        end
        #1;
        check(tg);
    endtask

    task automatic to_hugging();
        step(1'b1, 1'b0, 1'b0);   // search -> blocked
        step(1'b0, 1'b0, 1'b0);   // blocked -> gap
        step(1'b0, 1'b1, 1'b0);   // gap -> hugging
    endtask

    initial begin : watchdog
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1);            // R1 reset ignores feelers
        step(1'b0, 1'b0, 1'b0);            // R2 search hold
        step(1'b0, 1'b1, 1'b0);            // R2 right touch -> blocked
        step(1'b1, 1'b1, 1'b0);            // R3 hold
        step(1'b0, 1'b1, 1'b0);            // R3 hold
        step(1'b0, 1'b0, 1'b0);            // R3 -> gap
        step(1'b1, 1'b0, 1'b0);            // R5 left ignored
        step(1'b1, 1'b0, 1'b0);            // R5 left ignored
        step(1'b0, 1'b1, 1'b0);            // R5 -> hugging
        step(1'b0, 1'b1, 1'b0);            // R4 stay
        step(1'b1, 1'b1, 1'b0);            // R4 left wins -> blocked
        step(1'b0, 1'b0, 1'b1);            // R1 reset
        step(1'b1, 1'b0, 1'b0);            // R2 left touch -> blocked
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);            // to hugging
        step(1'b0, 1'b0, 1'b0);            // R4 none -> gap
        step(1'b0, 1'b1, 1'b0);            // back to hugging
        step(1'b1, 1'b0, 1'b0);            // R4 left only -> blocked
        step(1'b0, 1'b0, 1'b1);
        to_hugging();
        step(1'b0, 1'b0, 1'b1);            // R1 reset from hugging
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[3], (lfsr[15:10] == 6'h00));
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule